// File: doc/BRIEF.md
# Multiplexed Strip-Amplifier Readout Sequencer

This block runs the digital side of one event readout for a bank of charge-amplifier chips whose channels share a single analog output through a multiplexer. Several chips sit in a daisy chain, so one token walks through every channel of the chain. Two such chains are read side by side, and each chain feeds its own serial 12-bit converter. When a trigger arrives, the sequencer waits a programmable number of clocks so that the shaped pulse can reach its peak. It then freezes the sample-and-hold, loads the multiplexer token and steps it one channel at a time.

For every channel position, both converters run one framed serial conversion at the same time. The sequencer captures both 12-bit results and presents them together, with the channel index, as one write toward a downstream FIFO. After the final channel it releases the hold and the token and gives a one-cycle completion pulse. The block also drives the chips' reset line after a system reset. While that reset is active, and during a readout, incoming triggers are dropped.

With a 20 MHz clock, the peak of the shaped pulse comes about 130 clocks after the trigger. That value goes on the delay input.

Top module: `fe_readout_seq`

## Requirements
- R1: While `rst` is high, `chip_rst_o` and `busy_o` are 1, `adc_cs_o` is 1, and all other outputs are 0. After release, `chip_rst_o` stays 1 for exactly RST_CYCLES cycles and then drops together with `busy_o`. A trigger in that window is ignored.
- R2: In idle, a trigger sampled high at a clock edge starts a readout, and `busy_o` is 1 from that edge onward.
- R3: `hold_o` rises D clock edges after the trigger edge, where D is `hold_dly_i` (a value of 0 acts as 1). It stays high until the completion pulse.
- R4: A readout makes exactly one `mux_clk_o` pulse per channel. `tok_o` is high across the first pulse only.
- R5: One conversion frame holds `adc_cs_o` low for exactly 2*FRAME_CLKS clocks and gives FRAME_CLKS rising edges of `adc_sclk_o`. The serial clock is low whenever `adc_cs_o` is high.
- R6: The serial data is sampled on each rising `adc_sclk_o`. The first FRAME_CLKS-ADC_BITS bits are dropped, and the next ADC_BITS bits form the sample MSB first. Chain c appears in `fifo_data_o[c*ADC_BITS +: ADC_BITS]`.
- R7: Write k (counting from 0) has `fifo_ch_o` = k and occurs (2*FRAME_CLKS+4)*(k+1) cycles after the hold edge. There is exactly one write per channel.
- R8: One cycle after the last write, `done_o` pulses for a single cycle. In the same cycle `hold_o`, `tok_o` and `busy_o` go low.
- R9: A trigger during a readout is ignored. The readout's timing and data stay unchanged, and no further hold or write follows.
- R10: The multiplexer is never stepped while a conversion frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Event trigger, sampled on the clock |
| hold_dly_i | input | DLY_W | Clocks from trigger to hold |
| chip_rst_o | output | 1 | Reset line to the amplifier chips |
| hold_o | output | 1 | Sample-and-hold freeze |
| tok_o | output | 1 | Multiplexer shift-in token |
| mux_clk_o | output | 1 | Multiplexer step clock |
| adc_cs_o | output | 1 | Converter select, low during a frame |
| adc_sclk_o | output | 1 | Converter serial clock |
| adc_sdata_i | input | N_CHAINS | Serial data, one bit per chain |
| fifo_wr_o | output | 1 | Sample write strobe |
| fifo_ch_o | output | CH_W | Channel index of the write |
| fifo_data_o | output | N_CHAINS*ADC_BITS | Packed samples of all chains |
| busy_o | output | 1 | Readout or chip reset in progress |
| done_o | output | 1 | One-cycle end-of-readout pulse |

## Verification
Each result follows the trigger edge after a fixed number of cycles:
- `busy_o` is due 0 cycles after the trigger edge.
- `hold_o` is due D cycles after it.
- Write k is due D+36*(k+1) cycles after it, with the default 16-clock frame.
- `done_o` is due D+36*N+1 cycles after it, for N channels.

The bench keeps a free-running cycle count and stamps the trigger edge. It then compares each observed edge with these sums, sampling on the falling clock edge so that each registered output is read in the cycle it becomes valid. Frame length and serial-clock counts are taken per frame from the port waveforms. Sample values are compared with an arithmetic pattern that the converter model also sends, including passes whose leading bits are ones.

// File: rtl/fe_seq_pkg.sv
package fe_seq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WAIT,
    SQ_STEP_HI,
    SQ_STEP_LO,
    SQ_CONV,
    SQ_FIN
  } seq_state_t;
endpackage

// File: rtl/fe_adc_shift.sv
// Serial-in capture register for one chain; keeps only the newest W bits,
// so leading bits of a longer frame fall out of the top.
module fe_adc_shift #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (en) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/fe_adc_frame.sv
// One framed serial conversion on all chains at once.
module fe_adc_frame #(
  parameter int N_CHAINS   = 2,
  parameter int FRAME_CLKS = 16,
  parameter int ADC_BITS   = 12,
  localparam int PH_W      = $clog2(2 * FRAME_CLKS),
  localparam int DATA_W    = N_CHAINS * ADC_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [N_CHAINS-1:0] sdata_i,
  output logic                cs_o,
  output logic                sclk_o,
  output logic                done_o,
  output logic [DATA_W-1:0]   data_o
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * FRAME_CLKS - 1);

  logic            act;
  logic [PH_W-1:0] ph;
  logic            smp_en;

  // capture on the cycle that raises the serial clock
  assign smp_en = act & ~ph[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      act    <= 1'b0;
      ph     <= '0;
      cs_o   <= 1'b1;
      sclk_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!act) begin
        if (start) begin
          act  <= 1'b1;
          cs_o <= 1'b0;
          ph   <= '0;
        end
      end else begin
        ph <= ph + PH_W'(1);
        if (!ph[0]) begin
          sclk_o <= 1'b1;
        end else begin
          sclk_o <= 1'b0;
          if (ph == PH_LAST) begin
            act    <= 1'b0;
            cs_o   <= 1'b1;
            done_o <= 1'b1;
            ph     <= '0;
          end
        end
      end
    end
  end

  for (genvar c = 0; c < N_CHAINS; c++) begin : g_chain
    fe_adc_shift #(.W(ADC_BITS)) u_sh (
      .clk (clk),
      .rst (rst),
      .en  (smp_en),
      .din (sdata_i[c]),
      .q   (data_o[c*ADC_BITS +: ADC_BITS])
    );
  end
endmodule

// File: rtl/fe_seq_ctrl.sv
// Trigger, hold timing, token stepping, chip reset and sample hand-off.
module fe_seq_ctrl
  import fe_seq_pkg::*;
#(
  parameter int N_CH       = 192,
  parameter int DLY_W      = 16,
  parameter int RST_CYCLES = 4,
  parameter int DATA_W     = 24,
  localparam int CH_W      = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int RC_W      = $clog2(RST_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic [DLY_W-1:0]  dly_i,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic              adc_start,
  output logic              chip_rst_o,
  output logic              hold_o,
  output logic              tok_o,
  output logic              mux_clk_o,
  output logic              fifo_wr_o,
  output logic [CH_W-1:0]   fifo_ch_o,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [CH_W-1:0] LAST_CH  = CH_W'(N_CH - 1);
  localparam logic [RC_W-1:0] RC_LAST  = RC_W'(RST_CYCLES);
  localparam logic [DLY_W:0]  ONE_D    = (DLY_W + 1)'(1);

  seq_state_t       st;
  logic [DLY_W-1:0] dcnt;
  logic [CH_W-1:0]  ch;
  logic [RC_W-1:0]  rcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= SQ_IDLE;
      dcnt        <= '0;
      ch          <= '0;
      rcnt        <= '0;
      chip_rst_o  <= 1'b1;
      busy_o      <= 1'b1;
      hold_o      <= 1'b0;
      tok_o       <= 1'b0;
      mux_clk_o   <= 1'b0;
      adc_start   <= 1'b0;
      fifo_wr_o   <= 1'b0;
      fifo_ch_o   <= '0;
      fifo_data_o <= '0;
      done_o      <= 1'b0;
    end else begin
      adc_start <= 1'b0;
      fifo_wr_o <= 1'b0;
      done_o    <= 1'b0;

      if (chip_rst_o) begin
        rcnt <= rcnt + RC_W'(1);
        if (rcnt == RC_LAST) begin
          chip_rst_o <= 1'b0;
          busy_o     <= 1'b0;
        end
      end

      case (st)
        SQ_IDLE: begin
          if (trig_i && !busy_o) begin
            st     <= SQ_WAIT;
            busy_o <= 1'b1;
            dcnt   <= '0;
            ch     <= '0;
          end
        end
        SQ_WAIT: begin
          dcnt <= dcnt + DLY_W'(1);
          if (({1'b0, dcnt} + ONE_D) >= {1'b0, dly_i}) begin
            hold_o <= 1'b1;
            tok_o  <= 1'b1;
            st     <= SQ_STEP_HI;
          end
        end
        SQ_STEP_HI: begin
          mux_clk_o <= 1'b1;
          st        <= SQ_STEP_LO;
        end
        SQ_STEP_LO: begin
          mux_clk_o <= 1'b0;
          tok_o     <= 1'b0;
          adc_start <= 1'b1;
          st        <= SQ_CONV;
        end
        SQ_CONV: begin
          if (adc_done) begin
            fifo_wr_o   <= 1'b1;
            fifo_data_o <= adc_data;
            fifo_ch_o   <= ch;
            if (ch == LAST_CH) begin
              st <= SQ_FIN;
            end else begin
              ch <= ch + CH_W'(1);
              st <= SQ_STEP_HI;
            end
          end
        end
        SQ_FIN: begin
          hold_o <= 1'b0;
          done_o <= 1'b1;
          busy_o <= 1'b0;
          st     <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fe_readout_seq.sv
module fe_readout_seq #(
  parameter int N_CHAINS        = 2,
  parameter int CHIPS_PER_CHAIN = 3,
  parameter int CH_PER_CHIP     = 64,
  parameter int ADC_BITS        = 12,
  parameter int FRAME_CLKS      = 16,
  parameter int DLY_W           = 16,
  parameter int RST_CYCLES      = 4,
  localparam int CH_PER_CHAIN   = CHIPS_PER_CHAIN * CH_PER_CHIP,
  localparam int CH_W           = (CH_PER_CHAIN > 1) ? $clog2(CH_PER_CHAIN) : 1,
  localparam int DATA_W         = N_CHAINS * ADC_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trig_i,
  input  logic [DLY_W-1:0]    hold_dly_i,
  output logic                chip_rst_o,
  output logic                hold_o,
  output logic                tok_o,
  output logic                mux_clk_o,
  output logic                adc_cs_o,
  output logic                adc_sclk_o,
  input  logic [N_CHAINS-1:0] adc_sdata_i,
  output logic                fifo_wr_o,
  output logic [CH_W-1:0]     fifo_ch_o,
  output logic [DATA_W-1:0]   fifo_data_o,
  output logic                busy_o,
  output logic                done_o
);
  logic              adc_start;
  logic              adc_done;
  logic [DATA_W-1:0] adc_data;

  fe_seq_ctrl #(
    .N_CH       (CH_PER_CHAIN),
    .DLY_W      (DLY_W),
    .RST_CYCLES (RST_CYCLES),
    .DATA_W     (DATA_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .trig_i      (trig_i),
    .dly_i       (hold_dly_i),
    .adc_done    (adc_done),
    .adc_data    (adc_data),
    .adc_start   (adc_start),
    .chip_rst_o  (chip_rst_o),
    .hold_o      (hold_o),
    .tok_o       (tok_o),
    .mux_clk_o   (mux_clk_o),
    .fifo_wr_o   (fifo_wr_o),
    .fifo_ch_o   (fifo_ch_o),
    .fifo_data_o (fifo_data_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  fe_adc_frame #(
    .N_CHAINS   (N_CHAINS),
    .FRAME_CLKS (FRAME_CLKS),
    .ADC_BITS   (ADC_BITS)
  ) u_adc (
    .clk     (clk),
    .rst     (rst),
    .start   (adc_start),
    .sdata_i (adc_sdata_i),
    .cs_o    (adc_cs_o),
    .sclk_o  (adc_sclk_o),
    .done_o  (adc_done),
    .data_o  (adc_data)
  );
endmodule

// File: rtl/fe_readout_seq_chk.sv
module fe_readout_seq_chk #(
  parameter int FRAME_CLKS = 16
) (
  input logic clk,
  input logic rst,
  input logic trig_i,
  input logic chip_rst_o,
  input logic hold_o,
  input logic tok_o,
  input logic mux_clk_o,
  input logic adc_cs_o,
  input logic adc_sclk_o,
  input logic fifo_wr_o,
  input logic busy_o,
  input logic done_o
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) low_cnt <= '0;
    else if (!adc_cs_o) low_cnt <= low_cnt + 16'd1;
    else low_cnt <= '0;
  end

  a_r1_reset_blocks: assert property (@(posedge clk) disable iff (rst)
    chip_rst_o |-> (busy_o && !hold_o));
  a_r2_start_needs_trig: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(trig_i));
  a_r3_hold_ends_at_done: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_o) |-> done_o);
  a_r4_tok_in_hold: assert property (@(posedge clk) disable iff (rst)
    tok_o |-> hold_o);
  a_r5_sclk_idle: assert property (@(posedge clk) disable iff (rst)
    adc_cs_o |-> !adc_sclk_o);
  a_r5_frame_len: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_cs_o) |-> (low_cnt == 16'(2 * FRAME_CLKS)));
  a_r7_wr_in_hold: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_o |-> (hold_o && busy_o));
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r8_done_release: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!hold_o && !tok_o && !busy_o));
  a_r10_step_outside_frame: assert property (@(posedge clk) disable iff (rst)
    mux_clk_o |-> adc_cs_o);
endmodule

bind fe_readout_seq fe_readout_seq_chk #(.FRAME_CLKS(FRAME_CLKS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .trig_i     (trig_i),
  .chip_rst_o (chip_rst_o),
  .hold_o     (hold_o),
  .tok_o      (tok_o),
  .mux_clk_o  (mux_clk_o),
  .adc_cs_o   (adc_cs_o),
  .adc_sclk_o (adc_sclk_o),
  .fifo_wr_o  (fifo_wr_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/sim_fe_readout_seq.sv
`timescale 1ns/1ps
module sim_fe_readout_seq;
  localparam int NCH = 2;
  localparam int CPC = 2;
  localparam int CPP = 4;
  localparam int N   = CPC * CPP;
  localparam int AB  = 12;
  localparam int FR  = 16;
  localparam int DW  = 8;
  localparam int RC  = 3;
  localparam int CW  = $clog2(N);
  localparam int PER = 2 * FR + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig = 1'b0;
  logic [DW-1:0] dly = '0;
  logic chip_rst_o, hold_o, tok_o, mux_clk_o, adc_cs_o, adc_sclk_o;
  logic [NCH-1:0] sdata = '0;
  logic fifo_wr_o, busy_o, done_o;
  logic [CW-1:0] fifo_ch_o;
  logic [NCH*AB-1:0] fifo_data_o;

  always #2.5 clk = ~clk;

  fe_readout_seq #(
    .N_CHAINS(NCH), .CHIPS_PER_CHAIN(CPC), .CH_PER_CHIP(CPP), .ADC_BITS(AB),
    .FRAME_CLKS(FR), .DLY_W(DW), .RST_CYCLES(RC)
  ) u0 (
    .clk(clk), .rst(rst), .trig_i(trig), .hold_dly_i(dly),
    .chip_rst_o(chip_rst_o), .hold_o(hold_o), .tok_o(tok_o), .mux_clk_o(mux_clk_o),
    .adc_cs_o(adc_cs_o), .adc_sclk_o(adc_sclk_o), .adc_sdata_i(sdata),
    .fifo_wr_o(fifo_wr_o), .fifo_ch_o(fifo_ch_o), .fifo_data_o(fifo_data_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int t0, deff, wcnt, mcnt, fidx, bidx, pass_no, lowc, srises;
  bit in_run = 0, done_seen = 0, armed = 0;
  bit cs_q = 1, sclk_q = 0, hold_q = 0, mux_q = 0, csm_q = 1, sclkm_q = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] samp(input int p, input int c, input int k);
    if (p == 1) return (c == 0) ? 12'hFFF : 12'h000;
    if (p == 3) return k[0] ? 12'h555 : 12'hAAA;
    return 12'((p * 1237 + c * 2731 + k * 97 + 5) % 4096);
  endfunction

  function automatic logic [3:0] lead(input int p);
    return p[0] ? 4'hF : 4'h0;
  endfunction

  // converter model: first bit on select fall, next bit on each serial clock fall
  always @(posedge clk) begin
    #1;
    if (cs_q && !adc_cs_o) begin
      fidx++;
      bidx = 0;
    end else if (!adc_cs_o && sclk_q && !adc_sclk_o) begin
      bidx++;
    end
    cs_q = adc_cs_o;
    sclk_q = adc_sclk_o;
    for (int c = 0; c < NCH; c++) begin
      logic [15:0] w;
      w = {lead(pass_no), samp(pass_no, c, fidx)};
      sdata[c] = (bidx < 16) ? w[15 - bidx] : 1'b0;
    end
  end

  always @(negedge clk) begin
    if (!rst && armed) begin
      if (hold_o && !hold_q) begin
        if (in_run) chk(cyc == t0 + deff, "R3 hold delay", cyc - t0, deff);
        else chk(0, "R9 hold without accepted trigger", 1, 0);
      end
      if (mux_clk_o && !mux_q) begin
        mcnt++;
        chk(tok_o == (mcnt == 1), "R4 token on first step only", int'(tok_o), int'(mcnt == 1));
      end
      if (!adc_cs_o) begin
        lowc++;
        if (adc_sclk_o && !sclkm_q) srises++;
      end else if (!csm_q) begin
        chk(lowc == 2 * FR, "R5 frame length", lowc, 2 * FR);
        chk(srises == FR, "R5 serial clock edges", srises, FR);
        lowc = 0;
        srises = 0;
      end
      if (fifo_wr_o) begin
        if (!in_run) chk(0, "R9 write outside readout", 1, 0);
        else begin
          chk(int'(fifo_ch_o) == wcnt, "R7 channel index", int'(fifo_ch_o), wcnt);
          chk(cyc == t0 + deff + PER * (wcnt + 1), "R7 write timing", cyc - t0, deff + PER * (wcnt + 1));
          for (int c = 0; c < NCH; c++)
            chk(fifo_data_o[c*AB +: AB] == samp(pass_no, c, wcnt), "R6 sample value",
                int'(fifo_data_o[c*AB +: AB]), int'(samp(pass_no, c, wcnt)));
          wcnt++;
        end
      end
      if (done_o) begin
        chk(in_run, "R8 done without readout", int'(in_run), 1);
        chk(cyc == t0 + deff + PER * N + 1, "R8 done timing", cyc - t0, deff + PER * N + 1);
        chk(wcnt == N, "R7 write count", wcnt, N);
        chk(mcnt == N, "R4 step count", mcnt, N);
        chk(!hold_o && !busy_o && !tok_o, "R8 release at done", int'(hold_o | busy_o | tok_o), 0);
        in_run = 0;
        done_seen = 1;
      end
    end
    hold_q = hold_o;
    mux_q = mux_clk_o;
    csm_q = adc_cs_o;
    sclkm_q = adc_sclk_o;
  end

  task automatic readout(input int p, input int d, input bit retrig);
    @(negedge clk);
    pass_no = p;
    dly = DW'(d);
    deff = (d == 0) ? 1 : d;
    fidx = -1;
    wcnt = 0;
    mcnt = 0;
    done_seen = 0;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    t0 = cyc;
    in_run = 1;
    chk(busy_o == 1'b1, "R2 busy after trigger", int'(busy_o), 1);
    chk(hold_o == 1'b0, "R3 no early hold", int'(hold_o), 0);
    if (retrig) begin
      while (wcnt < 3) @(negedge clk);
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
    end
    while (!done_seen) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(!busy_o && !hold_o, "R9 idle after readout", int'(busy_o | hold_o), 0);
    chk(wcnt == N, "R9 no extra writes", wcnt, N);
  endtask

  initial begin
    int n;
    rst = 1'b1;
    dly = DW'(5);
    repeat (4) @(negedge clk);
    chk(chip_rst_o && busy_o, "R1 reset busy and chip reset", int'(chip_rst_o & busy_o), 1);
    chk(!hold_o && !tok_o && !mux_clk_o, "R1 reset strobes low", int'(hold_o | tok_o | mux_clk_o), 0);
    chk(adc_cs_o && !adc_sclk_o, "R1 reset converter idle", int'(adc_cs_o), 1);
    chk(!fifo_wr_o && !done_o, "R1 reset write and done low", int'(fifo_wr_o | done_o), 0);
    rst = 1'b0;
    armed = 1;
    trig = 1'b1;
    n = 0;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      if (j == 1) trig = 1'b0;
      if (chip_rst_o) n++;
    end
    chk(n == RC, "R1 chip reset length", n, RC);
    chk(!busy_o && !hold_o, "R1 trigger ignored in chip reset", int'(busy_o | hold_o), 0);
    readout(0, 1, 0);
    readout(1, 0, 0);
    readout(2, 130, 1);
    readout(3, 2, 0);
    readout(4, 7, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R7 watchdog expired: actual=%0d expected=%0d", wcnt, N);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule